// File: doc/BRIEF.md
# NRZI Line Encoder with Run-Length Bit Stuffing

This block turns a serial stream of data bits into an NRZI line level of the kind a USB transmitter drives. Each data bit is taken through a valid/ready handshake and sent for one bit-time. A zero flips the line and a one keeps it as it was. Bit-times are paced by a one-cycle `bit_tick` strobe from a bit-rate divider, so each output bit lasts from one enabled cycle to the next.

The encoder counts the ones sent in a row. When that count reaches the run limit (six by default), it sends an extra zero in the next bit-time. That extra zero is a line flip, and `in_ready` stays low for that bit-time so that no data bit is taken. The packet ends with the bit flagged by `in_last`. After that bit, and after any stuff bit that bit caused, the line holds for one more bit-time. The encoder then goes back to the idle level and pulses `done`.

The control is a four-state machine:
- IDLE: the line is at the idle level and the encoder waits for a first bit.
- SEND: the encoder takes data bits.
- STUFF: the stuff zero goes out.
- TAIL: the final bit is held on the line.

It has these transitions:
- start: IDLE to SEND, when the first bit is taken.
- run_hit: SEND or IDLE to STUFF, when the run of ones reaches the limit.
- resume: STUFF to SEND.
- finish: SEND or IDLE or STUFF to TAIL, after the last bit.
- release: TAIL to IDLE.

Top module: `nrzi_stuff_enc`

## Requirements
- R1: After reset, and in IDLE, `line_out` is 1, `in_ready` is 1 and `done` is 0.
- R2: A data bit 0 taken on a `bit_tick` cycle flips `line_out` at that clock edge.
- R3: A data bit 1 taken on a `bit_tick` cycle leaves `line_out` unchanged.
- R4: Once six ones in a row have been taken, the next bit-time is a stuff zero. In that bit-time `line_out` flips and `in_ready` is 0 for exactly that one bit-time, so the bit offered during it is not consumed.
- R5: The run of ones restarts at zero after a data 0, after a stuff bit, and at the start of every packet. Five ones followed by a zero cause no stuff bit, and twelve ones cause two stuff bits.
- R6: A data bit is consumed only on a cycle where `bit_tick`, `in_valid` and `in_ready` are all 1. On cycles with `bit_tick` at 0, `line_out` does not change.
- R7: During a packet, a `bit_tick` with `in_valid` at 0 leaves `line_out` and the run count unchanged.
- R8: The bit flagged by `in_last` is held on the line for one bit-time. If that bit completed a run of six, the stuff zero is sent first. At the end of the hold, `line_out` returns to 1 and `done` is 1 for one clock cycle.
- R9: The first bit of a packet is encoded relative to the idle level 1, so a first bit 0 gives line 0 and a first bit 1 gives line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe that starts each bit-time |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | Data bit value |
| in_last | input | 1 | The offered bit ends the packet |
| in_ready | output | 1 | The encoder can take a data bit in this bit-time |
| line_out | output | 1 | NRZI line level |
| done | output | 1 | One-cycle pulse when a packet has fully left the line |

## Verification
The bench builds the encoder with its default values: a run limit of six and an idle level of 1. With a limit of six, short packets of eight to twelve bits reach the stuffing cases:
- a stuff bit inside a packet;
- a stuff bit forced by the last bit;
- two stuff bits in a row-long packet;
- a near miss of five ones.

`bit_tick` arrives every fourth cycle. The cycles between strobes show that the line holds still without the strobe. A gap in `in_valid` in the middle of a run shows that the run count is kept across the gap.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_STUFF = 2'd2,
        ST_TAIL  = 2'd3
    } enc_state_t;
endpackage

// File: rtl/nrzi_run_counter.sv
module nrzi_run_counter #(
    parameter int RUN_LIMIT = 6,
    localparam int CW = $clog2(RUN_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + CW'(1);
    end

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(RUN_LIMIT));
endmodule

// File: rtl/nrzi_line_reg.sv
module nrzi_line_reg #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic park,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level <= IDLE_LEVEL;
        else if (park)
            level <= IDLE_LEVEL;
        else if (flip)
            level <= ~level;
    end
endmodule

// File: rtl/nrzi_stuff_enc.sv
module nrzi_stuff_enc
    import nrzi_pkg::*;
#(
    parameter int   RUN_LIMIT  = 6,
    parameter logic IDLE_LEVEL = 1'b1,
    localparam int  CW = $clog2(RUN_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic in_valid,
    input  logic in_data,
    input  logic in_last,
    output logic in_ready,
    output logic line_out,
    output logic done
);
    enc_state_t    state, state_nx;
    logic [CW-1:0] run_cnt;
    logic          take, run_hit, stuff_go, tail_go;
    logic          last_pend;

    assign in_ready = (state == ST_IDLE) || (state == ST_SEND);
    assign take     = bit_tick && in_valid && in_ready;
    assign run_hit  = take && in_data && (run_cnt == CW'(RUN_LIMIT - 1));
    assign stuff_go = (state == ST_STUFF) && bit_tick;
    assign tail_go  = (state == ST_TAIL) && bit_tick;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_SEND: begin
                if (take) begin
                    if (run_hit)      state_nx = ST_STUFF;
                    else if (in_last) state_nx = ST_TAIL;
                    else              state_nx = ST_SEND;
                end
            end
            ST_STUFF: if (bit_tick) state_nx = last_pend ? ST_TAIL : ST_SEND;
            ST_TAIL:  if (bit_tick) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            last_pend <= 1'b0;
        end else begin
            done <= tail_go;
            if (run_hit) last_pend <= in_last;
        end
    end

    nrzi_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((take && !in_data) || stuff_go || (state == ST_TAIL)),
        .inc   (take && in_data),
        .count (run_cnt)
    );

    nrzi_line_reg #(.IDLE_LEVEL(IDLE_LEVEL)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  ((take && !in_data) || stuff_go),
        .park  (tail_go),
        .level (line_out)
    );

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (line_out == IDLE_LEVEL));
    // R2
    zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_data) |=> (line_out != $past(line_out)));
    // R3
    one_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_data) |=> $stable(line_out));
    // R4
    stuff_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |=> (state == ST_STUFF && !in_ready));
    // R4
    stuff_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_go |=> (line_out != $past(line_out)));
    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(line_out));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE && line_out == IDLE_LEVEL));
endmodule

// File: tb/sim_nrzi_stuff_enc.sv
module sim_nrzi_stuff_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, in_valid = 1'b0, in_data = 1'b0, in_last = 1'b0;
    logic in_ready, line_out, done;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nrzi_stuff_enc u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .line_out(line_out), .done(done)
    );

    localparam int NPKT = 7;
    // data sent LSB first, length, bit index with a valid gap before it (-1 none), stuff bits expected
    localparam logic [31:0] PK_DATA [NPKT] = '{32'hA5, 32'hFF, 32'hFFF, 32'hDF, 32'h0, 32'h1, 32'h3F};
    localparam int PK_LEN   [NPKT] = '{8, 8, 12, 8, 4, 1, 6};
    localparam int PK_GAP   [NPKT] = '{-1, 3, -1, -1, -1, -1, -1};
    localparam int PK_STUFF [NPKT] = '{0, 1, 2, 0, 0, 0, 1};

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bit-time: strobe for one cycle, then three quiet cycles
    task automatic tick_quiet(input logic hold_lvl_chk);
        logic lvl;
        @(posedge clk); @(negedge clk);
        bit_tick = 1'b0;
        lvl = line_out;
        repeat (3) @(negedge clk);
        if (hold_lvl_chk) check(line_out == lvl, "R6 line still without tick", line_out, lvl);
    endtask

    task automatic run_packet(input int p);
        logic exp_line = 1'b1;
        int   run = 0, idx = 0, stuffs = 0;
        logic stuffing = 1'b0;
        logic b;
        logic gap_done = 1'b0;
        while (idx < PK_LEN[p] || stuffing) begin
            @(negedge clk);
            if (!stuffing && idx == PK_GAP[p] && !gap_done) begin
                gap_done = 1'b1;
                bit_tick = 1'b1; in_valid = 1'b0;
                check(in_ready == 1'b1, "R7 ready in gap", in_ready, 1);
                @(posedge clk); @(negedge clk);
                bit_tick = 1'b0;
                check(line_out == exp_line, "R7 gap holds line", line_out, exp_line);
                continue;
            end
            b = (idx < PK_LEN[p]) ? PK_DATA[p][idx] : 1'b0;
            bit_tick = 1'b1;
            in_valid = (idx < PK_LEN[p]);
            in_data  = b;
            in_last  = (idx == PK_LEN[p] - 1);
            check(in_ready == !stuffing, "R4 ready vs stuff", in_ready, !stuffing);
            @(posedge clk); @(negedge clk);
            bit_tick = 1'b0;
            if (stuffing) begin
                exp_line = ~exp_line; run = 0; stuffing = 1'b0; stuffs++;
                check(line_out == exp_line, "R4 stuff flips line", line_out, exp_line);
            end else begin
                if (!b) begin
                    exp_line = ~exp_line; run = 0;
                    check(line_out == exp_line, (idx == 0) ? "R9 first zero" : "R2 zero flips", line_out, exp_line);
                end else begin
                    run++;
                    if (run == 6) stuffing = 1'b1;
                    check(line_out == exp_line, (idx == 0) ? "R9 first one" : "R3 one holds", line_out, exp_line);
                end
                idx++;
            end
            in_valid = 1'b0; in_last = 1'b0;
            repeat (2) @(negedge clk);
            check(line_out == exp_line, "R6 no change between ticks", line_out, exp_line);
        end
        check(stuffs == PK_STUFF[p], "R5 stuff count", stuffs, PK_STUFF[p]);
        // tail bit-time
        @(negedge clk);
        check(in_ready == 1'b0 && done == 1'b0, "R8 tail not ready", in_ready, 0);
        bit_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_tick = 1'b0;
        check(done == 1'b1, "R8 done pulse", done, 1);
        check(line_out == 1'b1, "R8 line parked", line_out, 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
    endtask

    initial begin
        #20000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_out == 1'b1 && in_ready == 1'b1 && done == 1'b0, "R1 reset state", line_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        bit_tick = 1'b1;
        tick_quiet(1'b1);
        check(line_out == 1'b1, "R1 idle tick keeps level", line_out, 1);
        for (int p = 0; p < NPKT; p++) run_packet(p);
        // R6: data offered without tick is not consumed
        @(negedge clk);
        in_valid = 1'b1; in_data = 1'b0;
        repeat (4) @(negedge clk);
        check(line_out == 1'b1, "R6 no tick no consume", line_out, 1);
        // reset in the middle of a packet returns to idle
        bit_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_tick = 1'b0; in_valid = 1'b0;
        check(line_out == 1'b0, "R9 first zero directed", line_out, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(line_out == 1'b1 && in_ready == 1'b1, "R1 reset mid packet", line_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule